// File: doc/BRIEF.md
# Single-Line Span Read Cache

This block sits between a pixel-access engine and a byte-addressed surface memory. It holds one aligned line of the surface in local storage, 4096 bytes by default. Reads of 8, 16 or 32 bits are answered from that line. When a read falls outside the held line, the whole line is refetched over a 32-bit word port and the read is then answered from it.

Writes are not cached. Each write goes straight to memory with byte enables, and any write throws the held line away. A fourth access size covers pixel formats that have no alpha channel. As a read, it returns the stored word with its top byte forced to all ones. As a write, it stores only the three low bytes of the word.

The requester uses a valid/ready handshake and is held off while a refill or a memory write is in progress. A separate one-cycle invalidate input discards the line at any time.

Top module: `span_line_cache`

## Requirements
- R1: After reset `req_ready_o` is 1 and `rsp_valid_o` and `mem_valid_o` are 0. The first read after reset always refills the line.
- R2: A miss issues exactly LINE_BYTES/4 word reads (`mem_we_o`=0, `mem_be_o`=4'hF). Their addresses run consecutively, in steps of 4, from the request address with its low log2(LINE_BYTES) bits cleared. A request held with `mem_ready_i`=0 keeps its address. The read is answered after the last word returns.
- R3: A read whose aligned line base equals the held base issues no memory read. Its response appears in the cycle after acceptance.
- R4: Size code 0 returns the byte selected by addr[1:0], little-endian (addr[1:0]=0 is bits 7:0). Code 1 returns the half selected by addr[1], and addr[0] is ignored. Code 2 returns the whole word, and addr[1:0] is ignored. Results narrower than 32 bits are zero-extended.
- R5: Size code 3 on a read returns the addressed word ORed with 32'hFF000000.
- R6: A write issues one memory write to the word at addr with bits 1:0 cleared. The byte enables and lanes are as follows:
  - code 0: enable 1<<addr[1:0], with the byte copied to every lane.
  - code 1: enable 4'b0011 or 4'b1100 by addr[1], with the half copied to both halves.
  - code 2: enable 4'hF.
  - code 3: enable 4'b0111, which leaves byte 3 untouched.
- R7: Any accepted write invalidates the held line, so the next read of that line refills and returns the written data.
- R8: A pulse on `flush_i` invalidates the line, so the next read misses. A flush in the same cycle as an accepted read makes that read miss.
- R9: `req_ready_o` is 0 from the acceptance of a missing read until its response, and for as long as a memory write is pending.
- R10: A flush during a refill does not disturb the pending read, which is answered with the fetched data. The following read of that line refills again.
- R11: A read of a different line replaces the held line, so returning to the earlier line refills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard the held line |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 padded-alpha word |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata_o | output | 32 | Read data, zero-extended |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Read data returns, in order |
| mem_rdata_i | input | 32 | Returned read word |

## Verification
The hardest case to reach is a flush that lands while a refill is in flight. The refill must complete and answer its read, yet leave the line marked empty. The bench reaches it by starting a miss and pulsing the flush a fixed number of cycles into the wait. It then confirms that a second read of the same line costs a full refill. Memory back-pressure is switched on for some refills, so that word requests stall mid-sequence while their address must hold.

// File: rtl/span_cache_pkg.sv
package span_cache_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_PAD  = 2'd3
   } span_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_WRITE = 2'd3
   } span_state_e;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_BITS  = 8 * WORD_BYTES;
   localparam logic [WORD_BITS-1:0] ALPHA_ONES = 32'hFF00_0000;
endpackage

// File: rtl/span_line_store.sv
module span_line_store #(
   parameter int unsigned WORDS = 1024,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW   = $clog2(WORDS)
) (
   input  logic          clk_i,
   input  logic          wr_en_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [DW-1:0] rd_data_o
);
   logic [DW-1:0] line_q [WORDS];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) line_q[wr_idx_i] <= wr_data_i;
   end

   assign rd_data_o = line_q[rd_idx_i];
endmodule

// File: rtl/span_fill_seq.sv
module span_fill_seq #(
   parameter int unsigned WORDS = 1024,
   localparam int unsigned IW   = $clog2(WORDS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic          mem_ready_i,
   input  logic          mem_rvalid_i,
   output logic          issue_o,
   output logic [IW-1:0] issue_idx_o,
   output logic          recv_en_o,
   output logic [IW-1:0] recv_idx_o,
   output logic          done_o
);
   localparam logic [IW:0] CNT_END  = (IW+1)'(WORDS);
   localparam logic [IW:0] CNT_LAST = CNT_END - 1'b1;

   logic [IW:0] iss_q, rcv_q;
   logic        busy_q;

   assign issue_o     = busy_q && (iss_q < CNT_END);
   assign issue_idx_o = iss_q[IW-1:0];
   assign recv_en_o   = busy_q && mem_rvalid_i;
   assign recv_idx_o  = rcv_q[IW-1:0];
   assign done_o      = recv_en_o && (rcv_q == CNT_LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         iss_q  <= '0;
         rcv_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         iss_q  <= '0;
         rcv_q  <= '0;
      end else if (busy_q) begin
         if (issue_o && mem_ready_i) iss_q <= iss_q + 1'b1;
         if (recv_en_o)              rcv_q <= rcv_q + 1'b1;
         if (done_o)                 busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/span_lane_extract.sv
module span_lane_extract
   import span_cache_pkg::*;
(
   input  logic [WORD_BITS-1:0] word_i,
   input  logic [1:0]           off_i,
   input  logic [1:0]           size_i,
   output logic [WORD_BITS-1:0] data_o
);
   logic [7:0]  byte_sel;
   logic [15:0] half_sel;

   assign byte_sel = word_i[8*off_i +: 8];
   assign half_sel = off_i[1] ? word_i[31:16] : word_i[15:0];

   always_comb begin
      unique case (span_size_e'(size_i))
         SZ_BYTE: data_o = {24'd0, byte_sel};
         SZ_HALF: data_o = {16'd0, half_sel};
         SZ_WORD: data_o = word_i;
         default: data_o = word_i | ALPHA_ONES;
      endcase
   end
endmodule

// File: rtl/span_write_lanes.sv
module span_write_lanes
   import span_cache_pkg::*;
(
   input  logic [1:0]            off_i,
   input  logic [1:0]            size_i,
   input  logic [WORD_BITS-1:0]  wdata_i,
   output logic [WORD_BYTES-1:0] be_o,
   output logic [WORD_BITS-1:0]  data_o
);
   always_comb begin
      unique case (span_size_e'(size_i))
         SZ_BYTE: be_o = 4'b0001 << off_i;
         SZ_HALF: be_o = off_i[1] ? 4'b1100 : 4'b0011;
         SZ_WORD: be_o = 4'b1111;
         default: be_o = 4'b0111;
      endcase
   end

   for (genvar ln = 0; ln < WORD_BYTES; ln++) begin : g_lane
      always_comb begin
         unique case (span_size_e'(size_i))
            SZ_BYTE: data_o[8*ln +: 8] = wdata_i[7:0];
            SZ_HALF: data_o[8*ln +: 8] = wdata_i[8*(ln % 2) +: 8];
            default: data_o[8*ln +: 8] = wdata_i[8*ln +: 8];
         endcase
      end
   end
endmodule

// File: rtl/span_line_cache.sv
module span_line_cache
   import span_cache_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 4096
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_we_i,
   input  logic [1:0]        req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   output logic              rsp_valid_o,
   output logic [31:0]       rsp_rdata_o,
   output logic              mem_valid_o,
   input  logic              mem_ready_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [3:0]        mem_be_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_rvalid_i,
   input  logic [31:0]       mem_rdata_i
);
   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W = OFF_W - 2;
   localparam int unsigned WORDS = LINE_BYTES / WORD_BYTES;
   localparam int unsigned TAG_W = ADDR_W - OFF_W;
   localparam logic [TAG_W:0] TAG_EMPTY = {1'b1, {TAG_W{1'b0}}};

   initial begin
      assert (LINE_BYTES >= 8 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two of at least 8");
      assert (ADDR_W > OFF_W)
         else $error("ADDR_W must exceed the line offset width");
   end

   span_state_e       state_q;
   logic [TAG_W:0]    tag_q;
   logic              line_valid;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [1:0]        pend_size_q;
   logic              inv_seen_q;
   logic [ADDR_W-3:0] wr_waddr_q;
   logic [3:0]        wr_be_q;
   logic [31:0]       wr_data_q;
   logic              rsp_valid_q;
   logic [31:0]       rsp_data_q;

   logic              rd_acc, wr_acc, hit, fill_start;
   logic [ADDR_W-1:0] sel_addr;
   logic [1:0]        sel_size;
   logic [31:0]       line_word, ext_data;
   logic [3:0]        lane_be;
   logic [31:0]       lane_data;
   logic              fill_issue, fill_recv, fill_done;
   logic [IDX_W-1:0]  fill_issue_idx, fill_recv_idx;

   assign req_ready_o = (state_q == ST_IDLE);
   assign rd_acc      = req_valid_i && req_ready_o && !req_we_i;
   assign wr_acc      = req_valid_i && req_ready_o && req_we_i;
   assign line_valid  = !tag_q[TAG_W];
   assign hit         = line_valid && !flush_i &&
                        (tag_q[TAG_W-1:0] == req_addr_i[ADDR_W-1:OFF_W]);
   assign fill_start  = rd_acc && !hit;

   assign sel_addr = (state_q == ST_DRAIN) ? pend_addr_q : req_addr_i;
   assign sel_size = (state_q == ST_DRAIN) ? pend_size_q : req_size_i;

   span_line_store #(.WORDS(WORDS), .DW(WORD_BITS)) u_store (
      .clk_i     (clk_i),
      .wr_en_i   (fill_recv),
      .wr_idx_i  (fill_recv_idx),
      .wr_data_i (mem_rdata_i),
      .rd_idx_i  (sel_addr[OFF_W-1:2]),
      .rd_data_o (line_word)
   );

   span_fill_seq #(.WORDS(WORDS)) u_fill (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (fill_start),
      .mem_ready_i  (mem_ready_i),
      .mem_rvalid_i (mem_rvalid_i),
      .issue_o      (fill_issue),
      .issue_idx_o  (fill_issue_idx),
      .recv_en_o    (fill_recv),
      .recv_idx_o   (fill_recv_idx),
      .done_o       (fill_done)
   );

   span_lane_extract u_extract (
      .word_i (line_word),
      .off_i  (sel_addr[1:0]),
      .size_i (sel_size),
      .data_o (ext_data)
   );

   span_write_lanes u_lanes (
      .off_i   (req_addr_i[1:0]),
      .size_i  (req_size_i),
      .wdata_i (req_wdata_i),
      .be_o    (lane_be),
      .data_o  (lane_data)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         tag_q       <= TAG_EMPTY;
         pend_addr_q <= '0;
         pend_size_q <= '0;
         inv_seen_q  <= 1'b0;
         wr_waddr_q  <= '0;
         wr_be_q     <= '0;
         wr_data_q   <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         inv_seen_q  <= fill_start ? 1'b0 : (inv_seen_q | flush_i);

         if (flush_i || wr_acc) begin
            tag_q <= TAG_EMPTY;
         end else if (fill_done) begin
            tag_q <= inv_seen_q ? TAG_EMPTY
                                : {1'b0, pend_addr_q[ADDR_W-1:OFF_W]};
         end

         unique case (state_q)
            ST_IDLE: begin
               if (rd_acc) begin
                  pend_addr_q <= req_addr_i;
                  pend_size_q <= req_size_i;
                  if (hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= ext_data;
                  end else begin
                     state_q <= ST_FILL;
                  end
               end else if (wr_acc) begin
                  wr_waddr_q <= req_addr_i[ADDR_W-1:2];
                  wr_be_q    <= lane_be;
                  wr_data_q  <= lane_data;
                  state_q    <= ST_WRITE;
               end
            end
            ST_FILL: begin
               if (fill_done) state_q <= ST_DRAIN;
            end
            ST_DRAIN: begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= ext_data;
               state_q     <= ST_IDLE;
            end
            default: begin
               if (mem_ready_i) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_valid_o = (state_q == ST_WRITE) || fill_issue;
   assign mem_we_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = (state_q == ST_WRITE)
                      ? {wr_waddr_q, 2'b00}
                      : {pend_addr_q[ADDR_W-1:OFF_W], fill_issue_idx, 2'b00};
   assign mem_be_o    = (state_q == ST_WRITE) ? wr_be_q : 4'hF;
   assign mem_wdata_o = wr_data_q;
   assign rsp_valid_o = rsp_valid_q;
   assign rsp_rdata_o = rsp_data_q;
endmodule

// File: rtl/span_line_cache_chk.sv
module span_line_cache_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              flush_i,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic              req_we_i,
   input logic              mem_valid_o,
   input logic              mem_ready_i,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [3:0]        mem_be_o,
   input logic              rsp_valid_o,
   input logic [31:0]       rsp_rdata_o,
   input logic              line_valid,
   input logic [1:0]        pend_size_q
);
   p_busy_not_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_valid_o |-> !req_ready_o);

   p_mem_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && !mem_ready_i) |=>
         (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   p_fill_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && !mem_we_o) |-> (mem_addr_o[1:0] == 2'b00 && mem_be_o == 4'hF));

   p_write_be_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && mem_we_o) |-> (mem_be_o != 4'h0 && mem_addr_o[1:0] == 2'b00));

   p_write_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && req_we_i) |=> !line_valid);

   p_flush_inval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> !line_valid);

   p_pad_alpha_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && pend_size_q == 2'd3) |-> (rsp_rdata_o[31:24] == 8'hFF));

   p_byte_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && pend_size_q == 2'd0) |-> (rsp_rdata_o[31:8] == 24'd0));
endmodule

bind span_line_cache span_line_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .flush_i     (flush_i),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .req_we_i    (req_we_i),
   .mem_valid_o (mem_valid_o),
   .mem_ready_i (mem_ready_i),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_be_o    (mem_be_o),
   .rsp_valid_o (rsp_valid_o),
   .rsp_rdata_o (rsp_rdata_o),
   .line_valid  (line_valid),
   .pend_size_q (pend_size_q)
);

// File: tb/span_line_cache_tb_top.sv
`timescale 1ns/1ps
module span_line_cache_tb_top;
   localparam int unsigned AW    = 32;
   localparam int unsigned LINEB = 4096;
   localparam int unsigned LWORD = LINEB / 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_we = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic          mem_valid, mem_we, mem_ready, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          stall_en = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   span_line_cache #(.ADDR_W(AW), .LINE_BYTES(LINEB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
      .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
      .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
      .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
   );

   // backing memory model: 16 KB, one-cycle read return
   logic [31:0] bmem [0:4095];
   logic [3:0]  rdy_cnt;
   int          rd_total, wr_total;
   logic        seq_bad;
   logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
   logic [3:0]  last_wr_be;

   function automatic logic [31:0] init_word(int i);
      return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   assign mem_ready = stall_en ? (rdy_cnt[1:0] != 2'b11) : 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) bmem[i] <= init_word(i);
         rdy_cnt      <= '0;
         rd_total     <= 0;
         wr_total     <= 0;
         seq_bad      <= 1'b0;
         mem_rvalid   <= 1'b0;
         mem_rdata    <= '0;
         last_rd_addr <= '0;
         last_wr_addr <= '0;
         last_wr_data <= '0;
         last_wr_be   <= '0;
      end else begin
         rdy_cnt    <= rdy_cnt + 1'b1;
         mem_rvalid <= 1'b0;
         if (mem_valid && mem_ready) begin
            if (mem_we) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) bmem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
               wr_total     <= wr_total + 1;
               last_wr_addr <= mem_addr;
               last_wr_data <= mem_wdata;
               last_wr_be   <= mem_be;
            end else begin
               mem_rvalid   <= 1'b1;
               mem_rdata    <= bmem[mem_addr[13:2]];
               rd_total     <= rd_total + 1;
               last_rd_addr <= mem_addr;
               if (mem_addr[11:0] != 12'd0 && mem_addr != last_rd_addr + 32'd4)
                  seq_bad <= 1'b1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(logic [31:0] a, logic [1:0] sz);
      logic [31:0] w;
      w = bmem[a[13:2]];
      case (sz)
         2'd0:    return {24'd0, w[8*a[1:0] +: 8]};
         2'd1:    return {16'd0, (a[1] ? w[31:16] : w[15:0])};
         2'd2:    return w;
         default: return w | 32'hFF00_0000;
      endcase
   endfunction

   task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                          input bit fl_now, input int fl_delay,
                          output logic [31:0] d, output int nrd, output int lat,
                          output bit rdy_busy);
      int t0;
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b0; req_size = sz; req_addr = a;
      flush = fl_now;
      t0 = rd_total;
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      lat = 0; rdy_busy = 1'b0;
      while (!rsp_valid) begin
         if (req_ready) rdy_busy = 1'b1;
         flush = (fl_delay > 0 && lat == fl_delay);
         @(negedge clk);
         lat++;
      end
      flush = 1'b0;
      d = rsp_rdata;
      nrd = rd_total - t0;
   endtask

   task automatic do_write(input logic [31:0] a, input logic [1:0] sz,
                           input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b1; req_size = sz; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
      while (!req_ready) @(negedge clk);
   endtask

   function automatic logic [3:0] exp_be(logic [1:0] off, logic [1:0] sz);
      case (sz)
         2'd0:    return 4'b0001 << off;
         2'd1:    return off[1] ? 4'b1100 : 4'b0011;
         2'd2:    return 4'b1111;
         default: return 4'b0111;
      endcase
   endfunction

   function automatic logic [31:0] exp_lanes(logic [31:0] wd, logic [1:0] sz);
      case (sz)
         2'd0:    return {4{wd[7:0]}};
         2'd1:    return {2{wd[15:0]}};
         default: return wd;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, e, pre, merged;
      int nrd, lat, wr0, hit_bad;
      bit rb;

      repeat (4) @(negedge clk);
      // R1: reset state
      check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0 && mem_valid == 1'b0, "R1 idle outputs",
            {30'd0, rsp_valid, mem_valid}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2: first read misses and fills line 0x1000
      do_read(32'h0000_1234, 2'd2, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == LWORD, "R1 first read refills", 32'(nrd), 32'(LWORD));
      check(!seq_bad && last_rd_addr == 32'h0000_1FFC, "R2 fill sequence",
            last_rd_addr, 32'h0000_1FFC);
      check(d == exp_read(32'h1234, 2'd2), "R2 miss data", d, exp_read(32'h1234, 2'd2));
      check(!rb, "R9 ready low during fill", 32'(rb), 32'd0);

      // R3: hit latency and no memory traffic
      do_read(32'h0000_1008, 2'd2, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == 0 && lat == 0, "R3 hit one cycle, no reads", 32'(nrd + lat), 32'd0);

      // R4 R5: sweep every offset and size over the held line
      hit_bad = 0;
      for (int sz = 0; sz < 4; sz++) begin
         for (int off = 0; off < LINEB; off += ((sz == 3) ? 3 : 1)) begin
            do_read(32'h0000_1000 + 32'(off), 2'(sz), 1'b0, 0, d, nrd, lat, rb);
            e = exp_read(32'h0000_1000 + 32'(off), 2'(sz));
            if (nrd != 0 || lat != 0) hit_bad++;
            check(d == e, (sz == 3) ? "R5 padded-alpha read" : "R4 read extraction", d, e);
         end
      end
      check(hit_bad == 0, "R3 sweep all hits", 32'(hit_bad), 32'd0);

      // R2 R11: another line under memory back-pressure, then return
      stall_en = 1'b1;
      do_read(32'h0000_2ABC, 2'd1, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == LWORD && !seq_bad && last_rd_addr == 32'h0000_2FFC,
            "R2 stalled fill", 32'(nrd), 32'(LWORD));
      check(d == exp_read(32'h2ABC, 2'd1), "R11 new line data", d, exp_read(32'h2ABC, 2'd1));
      do_read(32'h0000_1010, 2'd0, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == LWORD, "R11 old line refilled", 32'(nrd), 32'(LWORD));
      stall_en = 1'b0;

      // R6 R7: every write size at every byte offset
      for (int sz = 0; sz < 4; sz++) begin
         for (int off = 0; off < 4; off++) begin
            logic [31:0] wa, wd;
            wa = 32'h0000_1100 + 32'(16 * (4 * sz + off)) + 32'(off);
            wd = 32'hC3A5_0000 + 32'(sz * 257 + off * 17);
            pre = bmem[wa[13:2]];
            wr0 = wr_total;
            do_write(wa, 2'(sz), wd);
            e = exp_lanes(wd, 2'(sz));
            check(wr_total == wr0 + 1 && last_wr_addr == {wa[31:2], 2'b00},
                  "R6 write address", last_wr_addr, {wa[31:2], 2'b00});
            check(last_wr_be == exp_be(wa[1:0], 2'(sz)), "R6 byte enables",
                  {28'd0, last_wr_be}, {28'd0, exp_be(wa[1:0], 2'(sz))});
            merged = pre;
            for (int b = 0; b < 4; b++)
               if (exp_be(wa[1:0], 2'(sz))[b]) merged[8*b +: 8] = e[8*b +: 8];
            do_read({wa[31:2], 2'b00}, 2'd2, 1'b0, 0, d, nrd, lat, rb);
            check(nrd == LWORD, "R7 write invalidated line", 32'(nrd), 32'(LWORD));
            check(d == merged, (sz == 3) ? "R6 padded write keeps byte 3" : "R6 merged word",
                  d, merged);
         end
      end

      // R8: flush pulse alone, then same-cycle flush with a read
      do_read(32'h0000_1020, 2'd2, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == 0, "R3 line held before flush", 32'(nrd), 32'd0);
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      do_read(32'h0000_1020, 2'd2, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == LWORD, "R8 flush forces miss", 32'(nrd), 32'(LWORD));
      do_read(32'h0000_1024, 2'd0, 1'b1, 0, d, nrd, lat, rb);
      check(nrd == LWORD, "R8 flush beats same-cycle read", 32'(nrd), 32'(LWORD));
      check(d == exp_read(32'h1024, 2'd0), "R8 data after flush", d, exp_read(32'h1024, 2'd0));

      // R10: flush in the middle of a refill
      do_read(32'h0000_3FFE, 2'd1, 1'b0, 300, d, nrd, lat, rb);
      check(nrd == LWORD && d == exp_read(32'h3FFE, 2'd1), "R10 pending read answered",
            d, exp_read(32'h3FFE, 2'd1));
      do_read(32'h0000_3000, 2'd3, 1'b0, 0, d, nrd, lat, rb);
      check(nrd == LWORD, "R10 line left empty", 32'(nrd), 32'(LWORD));
      check(d == exp_read(32'h3000, 2'd3), "R5 padded read after refill", d,
            exp_read(32'h3000, 2'd3));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule